// File: doc/BRIEF.md
# Two-clock synchronous SRAM bank lane controller

This block sits between a 32-bit processor bus that uses dynamic bus sizing and one bank of synchronous SRAM whose chips are held permanently enabled. From the low address offset, the two transfer-size bits, the read/write line, the active-low address strobe and the upper address bits, it produces four active-low byte-lane write selects, an active-low enable for the read data buffers, and an active-low synchronous termination strobe. The termination strobe goes to the system's termination merge logic.

A matching read terminates straight from the address decode, so it completes in two clocks. A write is held back by a delayed copy of the address strobe, which is registered on the clock edge after the strobe asserts and drops as soon as the strobe negates. That delayed copy gates both the byte-lane selects and the termination strobe, so a write takes three clocks and no lane can be written before the address has settled. The bank match is a parameterised mask/value compare on the address. By default the bank is selected when bits 16, 17 and 18 are low and bit 30 is high.

Top module: `sram_lane_ctrl`

## Requirements
- R1: When the address does not match the bank (default: bit 30 high, bits 16, 17 and 18 low), `lane_we_n`, `rd_en_n` and `term_n` all stay high.
- R2: While `as_n` is high, `lane_we_n`, `rd_en_n` and `term_n` all stay high.
- R3: On a matching read (`rd_wr`=1), `rd_en_n` and `term_n` go low in the same cycle that `as_n` goes low, with no clock edge needed. `lane_we_n` stays all high during reads.
- R4: On a matching write (`rd_wr`=0), nothing asserts before the first rising clock edge at which `as_n` is sampled low. After that edge, `term_n` and the selected lanes of `lane_we_n` go low. `rd_en_n` stays high during writes.
- R5: When `as_n` returns high, the delayed strobe clears at once: write lanes and `term_n` go high without waiting for a clock edge.
- R6: Lane mapping: `lane_we_n[3]` drives D31–D24 (byte offset 0), `[2]` drives D23–D16 (offset 1), `[1]` drives D15–D8 (offset 2) and `[0]` drives D7–D0 (offset 3). The offset is `addr[1:0]`.
- R7: Size encoding on `siz`: 00 = long word (4 bytes), 01 = byte, 10 = word, 11 = three bytes. A write enables the lanes from its offset up to offset + size − 1, and never past offset 3.
- R8: A long-word write enables every lane from its offset to offset 3, whatever the alignment. A write always asserts at least the lane at its own offset.
- R9: During reset, all outputs are high, and the delayed strobe is cleared so that no write lane asserts in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Bus address (offset in bits 1:0) |
| siz | input | 2 | Transfer size code |
| rd_wr | input | 1 | 1 = read, 0 = write |
| as_n | input | 1 | Active-low address strobe |
| lane_we_n | output | 4 | Active-low byte-lane write selects |
| rd_en_n | output | 1 | Active-low read buffer enable |
| term_n | output | 1 | Active-low synchronous termination |

## Verification
The bench builds the block with its default parameters: a 32-bit address and the default bank mask and match. With these values it can reach both the in-bank window at 0x4000_0000 and addresses just outside it, where a single one of bits 16, 17 or 18 is set or bit 30 is clear. Every one of the sixteen offset and size combinations is written with the default four-lane port, which covers the clipping of long-word and three-byte writes at the end of the port. Each write is observed before and after the stretching edge, and again after the strobe is released.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   localparam int PORT_BYTES = 4;
   localparam int OFF_W      = $clog2(PORT_BYTES);

   typedef enum logic [1:0] {
      SZ_LONG   = 2'b00,
      SZ_BYTE   = 2'b01,
      SZ_WORD   = 2'b10,
      SZ_TRIPLE = 2'b11
   } xfer_size_e;

   // number of bytes carried by a size code
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (xfer_size_e'(code))
         SZ_BYTE:   size_bytes = 3'd1;
         SZ_WORD:   size_bytes = 3'd2;
         SZ_TRIPLE: size_bytes = 3'd3;
         default:   size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
   parameter int              ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BANK_MASK  = '0,
   parameter logic [ADDR_W-1:0] BANK_MATCH = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   if ((BANK_MATCH & ~BANK_MASK) != '0) begin : g_bad_match
      $error("BANK_MATCH has bits outside BANK_MASK");
   end

   always_comb begin
      hit = ((addr & BANK_MASK) == BANK_MATCH);
   end

endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
   import sram_lane_pkg::*;
#(
   parameter int LANES = PORT_BYTES,
   localparam int OW   = $clog2(LANES),
   localparam int SW   = OW + 3
) (
   input  logic [OW-1:0]    offset,
   input  logic [1:0]       siz,
   output logic [LANES-1:0] lane_en   // indexed by byte offset
);

   logic [SW-1:0] first_b;
   logic [SW-1:0] last_b;

   always_comb begin
      first_b = SW'(offset);
      last_b  = first_b + SW'(size_bytes(siz)) - SW'(1);
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
         lane_en[k] = (SW'(k) >= first_b) && (SW'(k) <= last_b);
      end
   end

endmodule

// File: rtl/sram_strobe_delay.sv
module sram_strobe_delay (
   input  logic clk,
   input  logic rst_n,
   input  logic as_act,
   output logic das
);

   logic as_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) as_q <= 1'b0;
      else        as_q <= as_act;
   end

   // registered copy, cleared at once by strobe negation
   always_comb begin
      das = as_q & as_act;
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BANK_MASK  = ADDR_W'(32'h4007_0000),
   parameter logic [ADDR_W-1:0] BANK_MATCH = ADDR_W'(32'h4000_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        siz,
   input  logic              rd_wr,
   input  logic              as_n,
   output logic [3:0]        lane_we_n,
   output logic              rd_en_n,
   output logic              term_n
);

   localparam int LANES = PORT_BYTES;

   if (ADDR_W <= OFF_W) begin : g_bad_width
      $error("ADDR_W must exceed the offset width");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("lane output is fixed at four byte lanes");
   end

   logic             hit;
   logic             das;
   logic [LANES-1:0] lane_en;
   logic             as_act;
   logic             rd_ok;
   logic             wr_ok;

   assign as_act = ~as_n;

   sram_bank_decode #(
      .ADDR_W    (ADDR_W),
      .BANK_MASK (BANK_MASK),
      .BANK_MATCH(BANK_MATCH)
   ) u_bank (
      .addr(addr),
      .hit (hit)
   );

   sram_lane_decode #(.LANES(LANES)) u_lane (
      .offset (addr[OFF_W-1:0]),
      .siz    (siz),
      .lane_en(lane_en)
   );

   sram_strobe_delay u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .as_act(as_act),
      .das   (das)
   );

   always_comb begin
      rd_ok   = as_act & hit & rd_wr;
      wr_ok   = das & hit & ~rd_wr;
      rd_en_n = ~rd_ok;
      term_n  = ~(rd_ok | wr_ok);
   end

   // byte offset k drives bit LANES-1-k (offset 0 = top data byte)
   for (genvar k = 0; k < LANES; k++) begin : g_we
      always_comb begin
         lane_we_n[LANES-1-k] = ~(wr_ok & lane_en[k]);
      end
   end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BANK_MASK  = '0,
   parameter logic [ADDR_W-1:0] BANK_MATCH = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        siz,
   input logic              rd_wr,
   input logic              as_n,
   input logic [3:0]        lane_we_n,
   input logic              rd_en_n,
   input logic              term_n
);

   // R1
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr & BANK_MASK) != BANK_MATCH) |-> (&lane_we_n && rd_en_n && term_n));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |-> (&lane_we_n && rd_en_n && term_n));

   // R3
   read_no_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wr |-> &lane_we_n);

   // R3
   rden_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_n |-> (rd_wr && !term_n));

   // R4
   write_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!term_n && !rd_wr) |-> $past(!as_n));

   // R8
   write_lane_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_wr |-> (term_n == &lane_we_n));

   // R8
   lane_single_or_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&lane_we_n) |-> ($countones(~lane_we_n) >= 1 && !term_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .BANK_MASK (BANK_MASK),
   .BANK_MATCH(BANK_MATCH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .siz      (siz),
   .rd_wr    (rd_wr),
   .as_n     (as_n),
   .lane_we_n(lane_we_n),
   .rd_en_n  (rd_en_n),
   .term_n   (term_n)
);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] addr = '0;
   logic [1:0]  siz = 2'b00;
   logic        rd_wr = 1'b1;
   logic        as_n = 1'b1;
   logic [3:0]  lane_we_n;
   logic        rd_en_n;
   logic        term_n;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_lane_ctrl dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .siz(siz), .rd_wr(rd_wr),
      .as_n(as_n), .lane_we_n(lane_we_n), .rd_en_n(rd_en_n), .term_n(term_n)
   );

   // outputs packed as {lane_we_n, rd_en_n, term_n}
   task automatic check(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {lane_we_n, rd_en_n, term_n};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // expected active-high lane set, bit 3 = offset 0 (R6, R7, R8)
   function automatic logic [3:0] exp_lanes(input logic [1:0] off, input logic [1:0] sz);
      logic l0, l1, l2, l3;
      int   nb;
      nb = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : (sz == 2'b11) ? 3 : 4;
      l0 = (off == 2'd0);
      l1 = (off == 2'd1) || (off == 2'd0 && sz != 2'b01);
      l2 = (off == 2'd2) || (off == 2'd1 && sz != 2'b01)
           || (off == 2'd0 && (sz == 2'b00 || sz == 2'b11));
      l3 = (off == 2'd3) || (int'(off) + nb >= 4);
      return {l0, l1, l2, l3};
   endfunction

   task automatic next_drive();
      @(posedge clk); #1;
   endtask

   task automatic sample();
      @(negedge clk);
   endtask

   task automatic test_reset();
      // R9: during reset everything high, then no write lane in first cycle
      sample();
      check("R9 reset", 6'b111111);
      rst_n = 1'b1;
      next_drive();
      addr = BASE; siz = 2'b00; rd_wr = 1'b0; as_n = 1'b0;
      sample();
      check("R9 first cycle", 6'b111111);
      next_drive();
      as_n = 1'b1;
      next_drive();
   endtask

   task automatic test_write(input logic [1:0] off, input logic [1:0] sz);
      logic [3:0] lanes;
      lanes = exp_lanes(off, sz);
      addr = BASE | 32'(off); siz = sz; rd_wr = 1'b0; as_n = 1'b0;
      sample();
      check("R4 before stretch", 6'b111111);
      next_drive();
      sample();
      check("R7 R8 write lanes", {~lanes, 1'b1, 1'b0});
      next_drive();
      as_n = 1'b1;
      #1;
      check("R5 release", 6'b111111);
      next_drive();
   endtask

   task automatic test_read(input logic [1:0] off, input logic [1:0] sz);
      addr = BASE | 32'(off); siz = sz; rd_wr = 1'b1; as_n = 1'b0;
      #1;
      check("R3 read same cycle", 6'b111100);
      sample();
      check("R3 read held", 6'b111100);
      next_drive();
      as_n = 1'b1;
      #1;
      check("R2 read release", 6'b111111);
      next_drive();
   endtask

   task automatic test_miss(input logic [31:0] a, input logic rw);
      addr = a; siz = 2'b00; rd_wr = rw; as_n = 1'b0;
      sample();
      check("R1 miss", 6'b111111);
      next_drive();
      sample();
      check("R1 miss held", 6'b111111);
      next_drive();
      as_n = 1'b1;
      next_drive();
   endtask

   task automatic test_idle();
      addr = BASE; siz = 2'b00; rd_wr = 1'b1; as_n = 1'b1;
      sample();
      check("R2 idle read", 6'b111111);
      rd_wr = 1'b0;
      next_drive();
      sample();
      check("R2 idle write", 6'b111111);
      next_drive();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: got running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      test_reset();
      test_idle();
      for (int o = 0; o < 4; o++) begin
         for (int s = 0; s < 4; s++) begin
            test_write(2'(o), 2'(s));
         end
      end
      test_read(2'd0, 2'b00);
      test_read(2'd3, 2'b01);
      test_miss(32'h4001_0000, 1'b1);
      test_miss(32'h4002_0000, 1'b0);
      test_miss(32'h4004_0000, 1'b0);
      test_miss(32'h0000_0000, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule